// File: doc/BRIEF.md
# Dirty Band Scan Coalescer

This block tracks which horizontal bands of a frame buffer have changed since they were last drawn and turns them into a short list of update rectangles for the display refresh path. A band is four display lines. At a fixed stride of 1024 bytes per line, one band fills exactly one 4096-byte page of the 8-bit index plane. The block snoops write addresses on three planes and sets one dirty bit for each affected band. In deep-colour mode, the direct-colour plane and the control plane are four times larger than the index plane, so each band there covers 16384 bytes.

A refresh pass walks the bands from the top of the frame to the bottom, one band per cycle. Each run of adjacent dirty bands leaves the block as one rectangle, given as a start line and a line count. The x offset is always zero and the width is the configured frame width. When the walk ends, the dirty bits are cleared from the lowest to the highest band found dirty, so that band is redrawn only once. A write that lands during the walk, on a band the walk has already passed, keeps its bit. An invalidate input marks the whole frame as dirty. A pass whose output pixel format cannot be rendered does nothing.

Top module: `band_coalescer`

## Requirements
- R1: An index-plane write (wr_plane 0) at byte address A marks band A>>12, in either mode. A write whose band number is NUM_BANDS or larger marks nothing.
- R2: With deep_mode high, a write to the direct plane (wr_plane 1) or the control plane (wr_plane 2) at byte address A marks band A>>14. With deep_mode low, such writes mark nothing. A write with wr_plane 3 never marks anything.
- R3: A pass emits one rectangle for each run of consecutive dirty bands, in ascending order. The rectangle has rect_y = 4 × (first band) and rect_h = 4 × (run length).
- R4: A pass examines bands 0 to N-1, where N = ceil(frame_lines / 4) capped at NUM_BANDS. A run still open at the end is emitted with rect_h = 4 × N − rect_y. The last band of the buffer is included.
- R5: At the end of a pass, dirty bits are cleared only from the lowest to the highest dirty band seen, inclusive. Bands beyond the examined range keep their state.
- R6: A band written while a pass is running stays dirty after that pass. This holds for a band the pass has already passed, and for a band not yet reached, which is drawn in this pass and again in the next. A set wins over a clear in the same cycle.
- R7: A pulse on invalidate marks every band dirty.
- R8: Reset clears every dirty bit. After reset, busy and rect_valid are low.
- R9: A refresh_start is accepted only for a supported format: pix_bpp of 8, 15, 16 or 32 with deep_mode low, or 32 with deep_mode high. Otherwise nothing happens: busy stays low, no rectangle is emitted and no bit is cleared.
- R10: Rectangles use valid/ready. While rect_valid is high and rect_ready is low, rect_valid, rect_y and rect_h hold. rect_x is always 0 and rect_w always equals frame_width.
- R11: busy rises in the cycle after an accepted refresh_start. It stays high until the pass has emitted all its rectangles and applied its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deep_mode | input | 1 | Deep-colour mode; enables direct and control plane snooping |
| pix_bpp | input | 6 | Output pixel format in bits per pixel |
| frame_lines | input | LINE_W | Frame height in lines |
| frame_width | input | WIDTH_W | Frame width reported in every rectangle |
| wr_en | input | 1 | Snooped write strobe |
| wr_plane | input | 2 | Plane of the snooped write: 0 index, 1 direct, 2 control, 3 none |
| wr_addr | input | ADDR_W | Byte address of the write within its plane |
| invalidate | input | 1 | Mark all bands dirty |
| refresh_start | input | 1 | Start a refresh pass |
| busy | output | 1 | A pass is in progress |
| rect_valid | output | 1 | Rectangle available |
| rect_ready | input | 1 | Consumer accepts the rectangle |
| rect_x | output | WIDTH_W | Rectangle left edge, always 0 |
| rect_y | output | LINE_W | Rectangle first line |
| rect_w | output | WIDTH_W | Rectangle width |
| rect_h | output | LINE_W | Rectangle line count |

## Verification
The dirty patterns are chosen so that each one separates a single behaviour. A lone band tests address-to-band decoding. An adjacent group next to an isolated band distinguishes merging from splitting. A band at the very bottom exercises the flush of an open run at the end of the walk, and a full invalidate with a frame height that is not a multiple of four exercises the rounding and the limit of the clear range. Snooped writes are issued while the consumer stalls the output in mid-pass, one to a band already passed and one to a band ahead, which separates correct set-over-clear handling from a plain range clear. Format changes and deep-plane writes in both modes confirm that ignored traffic leaves the next pass's rectangles unchanged.

// File: rtl/band_scan_pkg.sv
package band_scan_pkg;

    // log2 of bytes covered by one band in the index plane
    localparam int PAGE_SHIFT = 12;
    // log2 of bytes covered by one band in the four-times larger planes
    localparam int DEEP_SHIFT = 14;
    // log2 of display lines per band
    localparam int BAND_LINES_LOG2 = 2;

    typedef enum logic [1:0] {
        PLANE_INDEX   = 2'd0,
        PLANE_DIRECT  = 2'd1,
        PLANE_CONTROL = 2'd2,
        PLANE_NONE    = 2'd3
    } plane_e;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_EMIT  = 2'd2,
        SC_CLEAR = 2'd3
    } scan_state_e;

    function automatic logic fmt_supported(input logic deep, input logic [5:0] bpp);
        if (deep) begin
            return bpp == 6'd32;
        end
        return (bpp == 6'd8) || (bpp == 6'd15) || (bpp == 6'd16) || (bpp == 6'd32);
    endfunction

endpackage

// File: rtl/band_snoop.sv
module band_snoop
    import band_scan_pkg::*;
#(
    parameter int NUM_BANDS = 192,
    parameter int ADDR_W    = 22
) (
    input  logic                 wr_en,
    input  logic [1:0]           wr_plane,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 deep_mode,
    input  logic                 invalidate,
    output logic [NUM_BANDS-1:0] set_vec
);

    plane_e              plane;
    logic                hit;
    logic [ADDR_W-1:0]   band_num;

    assign plane = plane_e'(wr_plane);

    always_comb begin
        hit      = 1'b0;
        band_num = '0;
        case (plane)
            PLANE_INDEX: begin
                hit      = wr_en;
                band_num = wr_addr >> PAGE_SHIFT;
            end
            PLANE_DIRECT, PLANE_CONTROL: begin
                hit      = wr_en & deep_mode;
                band_num = wr_addr >> DEEP_SHIFT;
            end
            default: begin
                hit      = 1'b0;
                band_num = '0;
            end
        endcase
    end

    // Band numbers at or above NUM_BANDS match no slot and are dropped.
    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_set
        assign set_vec[g] = invalidate | (hit && (band_num == ADDR_W'(g)));
    end

endmodule

// File: rtl/band_dirty_array.sv
module band_dirty_array #(
    parameter int NUM_BANDS = 192,
    parameter int IDX_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANDS-1:0] set_vec,
    input  logic                 scan_begin,
    input  logic                 busy,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_lo,
    input  logic [IDX_W-1:0]     clr_hi,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_dirty
);

    logic [NUM_BANDS-1:0] dirty_q;
    logic [NUM_BANDS-1:0] fresh_q;   // set while a pass runs, protects against its clear
    logic [NUM_BANDS-1:0] clr_mask;

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_mask
        assign clr_mask[g] = clr_en && (IDX_W'(g) >= clr_lo) && (IDX_W'(g) <= clr_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty_q <= '0;
            fresh_q <= '0;
        end else begin
            dirty_q <= set_vec | (dirty_q & ~(clr_mask & ~fresh_q));
            if (scan_begin) begin
                fresh_q <= '0;
            end else if (busy) begin
                fresh_q <= fresh_q | set_vec;
            end
        end
    end

    always_comb begin
        rd_dirty = 1'b0;
        for (int i = 0; i < NUM_BANDS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_dirty = dirty_q[i];
            end
        end
    end

endmodule

// File: rtl/band_scanner.sv
module band_scanner
    import band_scan_pkg::*;
#(
    parameter int NUM_BANDS = 192,
    parameter int IDX_W     = 8,
    parameter int LINE_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              refresh_start,
    input  logic              fmt_ok,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic              rd_dirty,
    input  logic              rect_ready,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              scan_begin,
    output logic              busy,
    output logic              clr_en,
    output logic [IDX_W-1:0]  clr_lo,
    output logic [IDX_W-1:0]  clr_hi,
    output logic              rect_valid,
    output logic [LINE_W-1:0] rect_y,
    output logic [LINE_W-1:0] rect_h
);

    localparam int EDGE_W = IDX_W + BAND_LINES_LOG2;
    localparam int CMP_W  = (EDGE_W > LINE_W) ? EDGE_W : LINE_W;

    scan_state_e       state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  run_start_q;
    logic              run_open_q;
    logic              any_q;
    logic              at_end_q;
    logic [IDX_W-1:0]  lo_q;
    logic [IDX_W-1:0]  hi_q;
    logic [LINE_W-1:0] rect_y_q;
    logic [LINE_W-1:0] rect_h_q;

    logic              end_reached;
    logic [LINE_W-1:0] idx_line;
    logic [LINE_W-1:0] start_line;

    assign end_reached = (idx_q == IDX_W'(NUM_BANDS)) ||
                         (CMP_W'({idx_q, {BAND_LINES_LOG2{1'b0}}}) >= CMP_W'(frame_lines));
    assign idx_line    = LINE_W'({idx_q, {BAND_LINES_LOG2{1'b0}}});
    assign start_line  = LINE_W'({run_start_q, {BAND_LINES_LOG2{1'b0}}});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SC_IDLE;
            idx_q       <= '0;
            run_start_q <= '0;
            run_open_q  <= 1'b0;
            any_q       <= 1'b0;
            at_end_q    <= 1'b0;
            lo_q        <= '0;
            hi_q        <= '0;
            rect_y_q    <= '0;
            rect_h_q    <= '0;
        end else begin
            case (state_q)
                SC_IDLE: begin
                    if (refresh_start && fmt_ok) begin
                        state_q    <= SC_SCAN;
                        idx_q      <= '0;
                        run_open_q <= 1'b0;
                        any_q      <= 1'b0;
                        at_end_q   <= 1'b0;
                    end
                end
                SC_SCAN: begin
                    if (end_reached) begin
                        if (run_open_q) begin
                            rect_y_q   <= start_line;
                            rect_h_q   <= idx_line - start_line;
                            run_open_q <= 1'b0;
                            at_end_q   <= 1'b1;
                            state_q    <= SC_EMIT;
                        end else if (any_q) begin
                            state_q <= SC_CLEAR;
                        end else begin
                            state_q <= SC_IDLE;
                        end
                    end else if (rd_dirty) begin
                        if (!run_open_q) begin
                            run_open_q  <= 1'b1;
                            run_start_q <= idx_q;
                        end
                        if (!any_q) begin
                            lo_q <= idx_q;
                        end
                        hi_q  <= idx_q;
                        any_q <= 1'b1;
                        idx_q <= idx_q + IDX_W'(1);
                    end else if (run_open_q) begin
                        rect_y_q   <= start_line;
                        rect_h_q   <= idx_line - start_line;
                        run_open_q <= 1'b0;
                        state_q    <= SC_EMIT;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                SC_EMIT: begin
                    if (rect_ready) begin
                        if (at_end_q) begin
                            state_q <= SC_CLEAR;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                            state_q <= SC_SCAN;
                        end
                    end
                end
                SC_CLEAR: begin
                    state_q <= SC_IDLE;
                end
                default: state_q <= SC_IDLE;
            endcase
        end
    end

    assign rd_idx     = idx_q;
    assign scan_begin = (state_q == SC_IDLE) && refresh_start && fmt_ok;
    assign busy       = (state_q != SC_IDLE);
    assign clr_en     = (state_q == SC_CLEAR);
    assign clr_lo     = lo_q;
    assign clr_hi     = hi_q;
    assign rect_valid = (state_q == SC_EMIT);
    assign rect_y     = rect_y_q;
    assign rect_h     = rect_h_q;

endmodule

// File: rtl/band_coalescer.sv
module band_coalescer
    import band_scan_pkg::*;
#(
    parameter int NUM_BANDS  = 192,
    parameter int WIDTH_W    = 11,
    localparam int IDX_W     = $clog2(NUM_BANDS + 1),
    localparam int LINE_W    = $clog2(NUM_BANDS * 4 + 1),
    localparam int ADDR_W    = $clog2(NUM_BANDS) + DEEP_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               deep_mode,
    input  logic [5:0]         pix_bpp,
    input  logic [LINE_W-1:0]  frame_lines,
    input  logic [WIDTH_W-1:0] frame_width,
    input  logic               wr_en,
    input  logic [1:0]         wr_plane,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               invalidate,
    input  logic               refresh_start,
    output logic               busy,
    output logic               rect_valid,
    input  logic               rect_ready,
    output logic [WIDTH_W-1:0] rect_x,
    output logic [LINE_W-1:0]  rect_y,
    output logic [WIDTH_W-1:0] rect_w,
    output logic [LINE_W-1:0]  rect_h
);

    logic [NUM_BANDS-1:0] set_vec;
    logic                 fmt_ok;
    logic                 scan_begin;
    logic                 clr_en;
    logic [IDX_W-1:0]     clr_lo;
    logic [IDX_W-1:0]     clr_hi;
    logic [IDX_W-1:0]     rd_idx;
    logic                 rd_dirty;

    assign fmt_ok = fmt_supported(deep_mode, pix_bpp);

    band_snoop #(
        .NUM_BANDS (NUM_BANDS),
        .ADDR_W    (ADDR_W)
    ) u_snoop (
        .wr_en      (wr_en),
        .wr_plane   (wr_plane),
        .wr_addr    (wr_addr),
        .deep_mode  (deep_mode),
        .invalidate (invalidate),
        .set_vec    (set_vec)
    );

    band_dirty_array #(
        .NUM_BANDS (NUM_BANDS),
        .IDX_W     (IDX_W)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (set_vec),
        .scan_begin (scan_begin),
        .busy       (busy),
        .clr_en     (clr_en),
        .clr_lo     (clr_lo),
        .clr_hi     (clr_hi),
        .rd_idx     (rd_idx),
        .rd_dirty   (rd_dirty)
    );

    band_scanner #(
        .NUM_BANDS (NUM_BANDS),
        .IDX_W     (IDX_W),
        .LINE_W    (LINE_W)
    ) u_scan (
        .clk           (clk),
        .rst           (rst),
        .refresh_start (refresh_start),
        .fmt_ok        (fmt_ok),
        .frame_lines   (frame_lines),
        .rd_dirty      (rd_dirty),
        .rect_ready    (rect_ready),
        .rd_idx        (rd_idx),
        .scan_begin    (scan_begin),
        .busy          (busy),
        .clr_en        (clr_en),
        .clr_lo        (clr_lo),
        .clr_hi        (clr_hi),
        .rect_valid    (rect_valid),
        .rect_y        (rect_y),
        .rect_h        (rect_h)
    );

    assign rect_x = '0;
    assign rect_w = frame_width;

endmodule

// File: rtl/band_scan_checker.sv
module band_scan_checker
    import band_scan_pkg::*;
#(
    parameter int LINE_W  = 10,
    parameter int WIDTH_W = 11
) (
    input logic               clk,
    input logic               rst,
    input logic               deep_mode,
    input logic [5:0]         pix_bpp,
    input logic               refresh_start,
    input logic               busy,
    input logic               rect_valid,
    input logic               rect_ready,
    input logic [WIDTH_W-1:0] rect_x,
    input logic [LINE_W-1:0]  rect_y,
    input logic [WIDTH_W-1:0] rect_w,
    input logic [WIDTH_W-1:0] frame_width,
    input logic [LINE_W-1:0]  rect_h
);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rect_valid && !rect_ready) |=> (rect_valid && $stable(rect_y) && $stable(rect_h)));

    p_geom_r10: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (rect_x == '0 && rect_w == frame_width));

    p_align_r3: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> (rect_h != '0 && rect_h[1:0] == 2'b00 && rect_y[1:0] == 2'b00));

    p_valid_busy_r11: assert property (@(posedge clk) disable iff (rst)
        rect_valid |-> busy);

    p_start_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && refresh_start && fmt_supported(deep_mode, pix_bpp)) |=> busy);

    p_skip_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !fmt_supported(deep_mode, pix_bpp)) |=> !busy);

endmodule

bind band_coalescer band_scan_checker #(
    .LINE_W  (LINE_W),
    .WIDTH_W (WIDTH_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .deep_mode     (deep_mode),
    .pix_bpp       (pix_bpp),
    .refresh_start (refresh_start),
    .busy          (busy),
    .rect_valid    (rect_valid),
    .rect_ready    (rect_ready),
    .rect_x        (rect_x),
    .rect_y        (rect_y),
    .rect_w        (rect_w),
    .frame_width   (frame_width),
    .rect_h        (rect_h)
);

// File: tb/band_coalescer_test.sv
module band_coalescer_test;

    localparam int NB = 192;
    localparam int LW = 10;
    localparam int WW = 11;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          deep_mode = 1'b0;
    logic [5:0]    pix_bpp = 6'd8;
    logic [LW-1:0] frame_lines = 10'd768;
    logic [WW-1:0] frame_width = 11'd1024;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_plane = 2'd0;
    logic [AW-1:0] wr_addr = '0;
    logic          invalidate = 1'b0;
    logic          refresh_start = 1'b0;
    logic          rect_ready = 1'b1;
    logic          busy;
    logic          rect_valid;
    logic [WW-1:0] rect_x;
    logic [WW-1:0] rect_w;
    logic [LW-1:0] rect_y;
    logic [LW-1:0] rect_h;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    int cyc = 0;
    bit mdl [NB];
    int exp_y [$];
    int exp_h [$];
    bit pv = 1'b0;
    logic [LW-1:0] py;
    logic [LW-1:0] ph;

    band_coalescer uut (
        .clk           (clk),
        .rst           (rst),
        .deep_mode     (deep_mode),
        .pix_bpp       (pix_bpp),
        .frame_lines   (frame_lines),
        .frame_width   (frame_width),
        .wr_en         (wr_en),
        .wr_plane      (wr_plane),
        .wr_addr       (wr_addr),
        .invalidate    (invalidate),
        .refresh_start (refresh_start),
        .busy          (busy),
        .rect_valid    (rect_valid),
        .rect_ready    (rect_ready),
        .rect_x        (rect_x),
        .rect_y        (rect_y),
        .rect_w        (rect_w),
        .rect_h        (rect_h)
    );

    initial forever #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic bit bench_fmt(input bit deep, input int bpp);
        if (deep) return bpp == 32;
        return bpp == 8 || bpp == 15 || bpp == 16 || bpp == 32;
    endfunction

    // Ready generation and rectangle comparison, once per clock away from the edge.
    always @(negedge clk) begin : mon
        int ey;
        int eh;
        cyc++;
        case (ready_mode)
            0:       rect_ready = 1'b1;
            1:       rect_ready = (cyc % 3) != 0;
            default: rect_ready = 1'b0;
        endcase
        if (!rst && pv) begin
            chk(rect_valid == 1'b1, "R10", "valid held", int'(rect_valid), 1);
            chk(rect_y == py, "R10", "rect_y held", int'(rect_y), int'(py));
            chk(rect_h == ph, "R10", "rect_h held", int'(rect_h), int'(ph));
        end
        if (!rst && rect_valid) begin
            chk(rect_x == '0, "R10", "rect_x", int'(rect_x), 0);
            chk(rect_w == frame_width, "R10", "rect_w", int'(rect_w), int'(frame_width));
            if (rect_ready) begin
                if (exp_y.size() == 0) begin
                    chk(1'b0, "R3", "unexpected rect_y", int'(rect_y), -1);
                end else begin
                    ey = exp_y.pop_front();
                    eh = exp_h.pop_front();
                    chk(int'(rect_y) == ey, "R3", "rect_y", int'(rect_y), ey);
                    chk(int'(rect_h) == eh, "R4", "rect_h", int'(rect_h), eh);
                end
            end
        end
        pv = !rst && rect_valid && !rect_ready;
        py = rect_y;
        ph = rect_h;
    end

    task automatic mark(input int plane, input int addr);
        int b;
        b = -1;
        if (plane == 0) b = addr / 4096;
        else if ((plane == 1 || plane == 2) && deep_mode) b = addr / 16384;
        if (b >= 0 && b < NB) mdl[b] = 1'b1;
    endtask

    task automatic wr(input int plane, input int addr);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_plane = plane[1:0];
        wr_addr  = addr[AW-1:0];
        @(negedge clk);
        wr_en = 1'b0;
        mark(plane, addr);
    endtask

    task automatic model_pass(input int lines);
        int n;
        int s;
        int lo;
        int hi;
        n = (lines + 3) / 4;
        if (n > NB) n = NB;
        s = -1; lo = -1; hi = -1;
        for (int b = 0; b < n; b++) begin
            if (mdl[b]) begin
                if (s < 0) s = b;
                if (lo < 0) lo = b;
                hi = b;
            end else if (s >= 0) begin
                exp_y.push_back(s * 4);
                exp_h.push_back((b - s) * 4);
                s = -1;
            end
        end
        if (s >= 0) begin
            exp_y.push_back(s * 4);
            exp_h.push_back((n - s) * 4);
        end
        if (lo >= 0) begin
            for (int b = lo; b <= hi; b++) mdl[b] = 1'b0;
        end
    endtask

    task automatic wait_idle(input string req);
        for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
        chk(busy == 1'b0, req, "busy at pass end", int'(busy), 0);
        chk(exp_y.size() == 0, req, "rects outstanding", exp_y.size(), 0);
        @(negedge clk);
    endtask

    task automatic run_pass(input int lines, input string req);
        bit go;
        @(negedge clk);
        frame_lines = lines[LW-1:0];
        go = bench_fmt(deep_mode, int'(pix_bpp));
        if (go) model_pass(lines);
        refresh_start = 1'b1;
        @(negedge clk);
        refresh_start = 1'b0;
        if (go) chk(busy == 1'b1, "R11", "busy after start", int'(busy), 1);
        else    chk(busy == 1'b0, "R9", "busy after unsupported start", int'(busy), 0);
        wait_idle(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
        chk(rect_valid == 1'b0, "R8", "rect_valid after reset", int'(rect_valid), 0);
        run_pass(768, "R8");

        // R1: single index-plane write
        wr(0, 5 * 4096 + 17);
        run_pass(768, "R1");

        // R1 / R2: out-of-range band and no-plane writes are dropped
        wr(0, NB * 4096 + 5);
        wr(3, 4096);
        run_pass(768, "R2");

        // R3: merge adjacent bands, split at a gap, stalled consumer
        ready_mode = 1;
        wr(0, 2 * 4096);
        wr(0, 3 * 4096 + 4095);
        wr(0, 4 * 4096);
        wr(0, 9 * 4096 + 100);
        run_pass(768, "R3");
        ready_mode = 0;

        // R2: deep planes ignored in shallow mode
        wr(1, 7 * 16384);
        wr(2, 9 * 16384);
        run_pass(768, "R2");

        // R2: deep planes counted in deep mode
        deep_mode = 1'b1;
        pix_bpp = 6'd32;
        wr(1, 7 * 16384 + 3 * 4096);
        wr(2, 8 * 16384);
        wr(0, 20 * 4096);
        run_pass(768, "R2");

        // R9: unsupported formats leave dirty state intact
        wr(0, 30 * 4096);
        pix_bpp = 6'd16;
        run_pass(768, "R9");
        deep_mode = 1'b0;
        pix_bpp = 6'd0;
        run_pass(768, "R9");
        pix_bpp = 6'd24;
        run_pass(768, "R9");
        pix_bpp = 6'd15;
        run_pass(768, "R9");

        // R7 / R4 / R5: invalidate, short frame, clear limited to scanned range
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        for (int b = 0; b < NB; b++) mdl[b] = 1'b1;
        run_pass(42, "R7");
        run_pass(768, "R5");

        // R4: last band flushed at end of frame
        wr(0, 191 * 4096 + 4000);
        run_pass(768, "R4");

        // R6: writes during a stalled pass
        wr(0, 1 * 4096);
        wr(0, 4 * 4096);
        mdl[1] = 1'b0;
        mdl[4] = 1'b0;
        exp_y.push_back(4);  exp_h.push_back(4);
        exp_y.push_back(16); exp_h.push_back(4);
        exp_y.push_back(40); exp_h.push_back(4);
        ready_mode = 2;
        @(negedge clk);
        frame_lines = 10'd768;
        refresh_start = 1'b1;
        @(negedge clk);
        refresh_start = 1'b0;
        for (int k = 0; k < 1000 && !rect_valid; k++) @(negedge clk);
        wr(0, 2 * 4096);
        wr(0, 10 * 4096);
        ready_mode = 0;
        wait_idle("R6");
        run_pass(768, "R6");

        // R8: reset clears pending bands
        wr(0, 50 * 4096);
        wr(0, 60 * 4096);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NB; b++) mdl[b] = 1'b0;
        run_pass(768, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule